// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

This block is a non-blocking crosspoint switch with sixteen single-bit input lanes and sixteen single-bit output lanes. Every output lane has its own selector, so it can pick any input lane without regard to what the others pick. Any number of outputs may pick the same input. Each output lane is registered, so data crosses the switch in one clock cycle.

Routing is held in two register ranks. The staging rank holds one input index per output. It is written one entry at a time: a binary output address picks the entry, and a binary input address gives the value stored while the write enable is high. The active rank drives the selectors. While the commit control is high, the active rank takes a copy of the whole staging rank in a single cycle. A host can therefore stage any number of route changes and apply them all together. Outputs whose route does not change keep passing data without a break.

A preset control sends every output to input 0 at once. It also reloads each staging entry with its own output number, so the next commit gives the identity map. All controls are sampled on the system clock as level enables. The asynchronous active-low reset puts the block in the same state as the preset and clears the output lanes.

Top module: `xpt_switch`

## Requirements
- R1: Each output lane is registered: `dout[k]` in a cycle equals the input lane that output k's active route selected, as sampled at the previous rising clock edge.
- R2: Every output has its own active route, and several outputs may select the same input in the same cycle.
- R3: While `load` is high and `preset` is low, the staging entry named by `out_sel` (binary, 0 = output 0, 15 = output 15) takes the value of `in_sel` (binary input number) at every clock edge. The last value sampled before `load` falls is kept. Other entries do not change.
- R4: While `load` is low, changes on `out_sel` and `in_sel` leave every staging entry unchanged.
- R5: Writes to the staging rank do not change the active routing until a commit.
- R6: While `configure` is high and `preset` is low, every active route takes the value its staging entry held before that clock edge, all in the same cycle. While `configure` is low, the active routes hold.
- R7: Across a commit, every output whose route value stays the same keeps carrying its input with one-cycle latency in every cycle.
- R8: A clock edge with `preset` high sets every active route to input 0 (broadcast). This holds even when `configure` is high in the same cycle.
- R9: A clock edge with `preset` high also sets staging entry k to k, so the next commit gives pass-through (input k to output k).
- R10: When `preset` and `load` are high in the same cycle, the preset wins and the write is dropped.
- R11: A low level on `rst_n` clears `dout` at once, without waiting for a clock edge, and leaves the routing in the preset state (broadcast active, identity staged). Operation resumes on the third rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| din | input | 16 | Input data lanes |
| out_sel | input | 4 | Binary number of the staging entry to write |
| in_sel | input | 4 | Binary input number stored into the chosen staging entry |
| load | input | 1 | Level write enable for the staging rank |
| configure | input | 1 | Level commit enable, staging rank to active rank |
| preset | input | 1 | Level preset: broadcast becomes active, identity is staged |
| dout | output | 16 | Registered output data lanes |

## Verification
The bench stages a batch of routes in which three outputs share one input, one output is written twice and one is rewritten with its current value. Before the commit it checks that nothing has moved yet. A design that routed writes straight to the selectors, or that applied only the last write, would show a wrong map on a one-hot sweep of the inputs. During a commit that changes one output only, the other fifteen outputs are checked every cycle under changing data, which catches a design that clears or stalls all lanes while it reconfigures. The bench also drives preset together with load, and preset together with configure. A design with the wrong priority would either keep the stray write in the later pass-through map or commit the staged routes instead of broadcast. An asynchronous reset pulse in the middle of a run must clear the outputs before the next clock edge.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  // Action that applies to both routing ranks in the current cycle.
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_PRESET = 2'd1,
    ACT_UPDATE = 2'd2
  } bank_act_e;

endpackage

// File: rtl/xpt_prog_bank.sv
module xpt_prog_bank
  import xpt_pkg::*;
#(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bank_act_e                act,
  input  logic                     load,
  input  logic [SEL_W-1:0]         out_sel,
  input  logic [SEL_W-1:0]         in_sel,
  output logic [N_PORTS*SEL_W-1:0] prog_flat
);

  localparam int FLAT_W = N_PORTS * SEL_W;

  function automatic logic [FLAT_W-1:0] make_ident();
    logic [FLAT_W-1:0] v;
    v = '0;
    for (int k = 0; k < N_PORTS; k++) v[k*SEL_W +: SEL_W] = SEL_W'(k);
    return v;
  endfunction

  localparam logic [FLAT_W-1:0] IDENT = make_ident();

  logic [FLAT_W-1:0] prog_q, prog_d;
  logic              prog_en;

  // Next state: preset reloads the identity map, otherwise one entry is written.
  always_comb begin
    prog_d  = prog_q;
    prog_en = 1'b0;
    if (act == ACT_PRESET) begin
      prog_d  = IDENT;
      prog_en = 1'b1;
    end else if (act == ACT_UPDATE && load) begin
      prog_en = 1'b1;
      for (int k = 0; k < N_PORTS; k++) begin
        if (out_sel == SEL_W'(k)) prog_d[k*SEL_W +: SEL_W] = in_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prog_q <= IDENT;
    else if (prog_en) prog_q <= prog_d;
  end

  assign prog_flat = prog_q;

endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
  import xpt_pkg::*;
#(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bank_act_e                act,
  input  logic                     configure,
  input  logic [N_PORTS*SEL_W-1:0] prog_flat,
  output logic [N_PORTS*SEL_W-1:0] cfg_flat
);

  localparam int FLAT_W = N_PORTS * SEL_W;

  logic [FLAT_W-1:0] cfg_q, cfg_d;
  logic              cfg_en;

  // Broadcast on preset; otherwise copy the whole staging rank on commit.
  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (act == ACT_PRESET) begin
      cfg_d  = '0;
      cfg_en = 1'b1;
    end else if (act == ACT_UPDATE && configure) begin
      cfg_d  = prog_flat;
      cfg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_flat = cfg_q;

endmodule

// File: rtl/xpt_lane_mux.sv
module xpt_lane_mux #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] din,
  input  logic [SEL_W-1:0]   sel,
  output logic               q
);

  logic q_d, q_r;

  always_comb q_d = din[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/xpt_switch.sv
module xpt_switch
  import xpt_pkg::*;
#(
  parameter int N_PORTS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PORTS-1:0]         din,
  input  logic [$clog2(N_PORTS)-1:0] out_sel,
  input  logic [$clog2(N_PORTS)-1:0] in_sel,
  input  logic                       load,
  input  logic                       configure,
  input  logic                       preset,
  output logic [N_PORTS-1:0]         dout
);

  localparam int SEL_W  = $clog2(N_PORTS);
  localparam int FLAT_W = N_PORTS * SEL_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  bank_act_e         act;
  logic [FLAT_W-1:0] prog_flat;
  logic [FLAT_W-1:0] cfg_flat;

  // Reset is asserted at once and released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    if (preset)                 act = ACT_PRESET;
    else if (load || configure) act = ACT_UPDATE;
    else                        act = ACT_IDLE;
  end

  xpt_prog_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_prog (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .act       (act),
    .load      (load),
    .out_sel   (out_sel),
    .in_sel    (in_sel),
    .prog_flat (prog_flat)
  );

  xpt_cfg_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .act       (act),
    .configure (configure),
    .prog_flat (prog_flat),
    .cfg_flat  (cfg_flat)
  );

  for (genvar k = 0; k < N_PORTS; k++) begin : g_lane
    xpt_lane_mux #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .din   (din),
      .sel   (cfg_flat[k*SEL_W +: SEL_W]),
      .q     (dout[k])
    );
  end

endmodule

// File: rtl/xpt_switch_chk.sv
module xpt_switch_chk #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_PORTS-1:0]       din,
  input logic [SEL_W-1:0]         out_sel,
  input logic [SEL_W-1:0]         in_sel,
  input logic                     load,
  input logic                     configure,
  input logic                     preset,
  input logic [N_PORTS-1:0]       dout,
  input logic [N_PORTS*SEL_W-1:0] prog_flat,
  input logic [N_PORTS*SEL_W-1:0] cfg_flat
);

  // R8: preset drives broadcast, even when a commit is requested too.
  p_preset_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> cfg_flat == '0);

  // R6: commit copies the staging rank as it stood before the edge.
  p_commit_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (configure && !preset) |=> cfg_flat == $past(prog_flat));

  // R6: without commit or preset the active routes hold.
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!configure && !preset) |=> $stable(cfg_flat));

  // R4: staging rank holds while load is low.
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !preset) |=> $stable(prog_flat));

  for (genvar k = 0; k < N_PORTS; k++) begin : g_chk
    // R3: the addressed entry takes in_sel.
    p_stage_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !preset && out_sel == SEL_W'(k))
        |=> prog_flat[k*SEL_W +: SEL_W] == $past(in_sel));

    // R9 and R10: preset stages the identity map and drops a write.
    p_preset_ident_r9: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> prog_flat[k*SEL_W +: SEL_W] == SEL_W'(k));

    // R1 and R7: with a steady route the lane carries its input one cycle later.
    p_lane_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(cfg_flat[k*SEL_W +: SEL_W]))
        |-> dout[k] == $past(din[cfg_flat[k*SEL_W +: SEL_W]]));
  end

endmodule

bind xpt_switch xpt_switch_chk #(.N_PORTS(N_PORTS), .SEL_W($clog2(N_PORTS))) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .din       (din),
  .out_sel   (out_sel),
  .in_sel    (in_sel),
  .load      (load),
  .configure (configure),
  .preset    (preset),
  .dout      (dout),
  .prog_flat (prog_flat),
  .cfg_flat  (cfg_flat)
);

// File: tb/sim_xpt_switch.sv
module sim_xpt_switch;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;
  localparam int SW         = 4;
  localparam int N_LOADS    = 9;

  // Each entry: {output number, input number}.
  localparam logic [7:0] LOADS [N_LOADS] = '{
    8'h05, 8'h15, 8'h25, 8'hF0, 8'h79, 8'h8C, 8'h73, 8'hAF, 8'h33
  };
  // Active map expected once the table above is committed over pass-through.
  localparam int EXP_MAP [N] = '{5, 5, 5, 3, 4, 5, 6, 3, 12, 9, 15, 11, 12, 13, 14, 0};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  din;
  logic [SW-1:0] out_sel, in_sel;
  logic          load, configure, preset;
  logic [N-1:0]  dout;

  int n_checks = 0;
  int n_fails  = 0;
  int cur_prog [N];
  int cur_act  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_switch #(.N_PORTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .out_sel(out_sel), .in_sel(in_sel),
    .load(load), .configure(configure), .preset(preset), .dout(dout)
  );

  task automatic chk(input logic [N-1:0] act_v, input logic [N-1:0] exp_v, input string req);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // One-hot sweep over all inputs against the bench's active map.
  task automatic check_map(input string req);
    for (int j = 0; j < N; j++) begin
      logic [N-1:0] e;
      din = N'(1) << j;
      cyc();
      for (int k = 0; k < N; k++) e[k] = (cur_act[k] == j);
      chk(dout, e, req);
    end
  endtask

  task automatic load_one(input int o, input int i);
    out_sel = SW'(o); in_sel = SW'(i); load = 1'b1;
    cyc();
    load = 1'b0;
    cur_prog[o] = i;
  endtask

  task automatic commit();
    configure = 1'b1;
    cyc();
    configure = 1'b0;
    for (int k = 0; k < N; k++) cur_act[k] = cur_prog[k];
  endtask

  task automatic model_preset();
    for (int k = 0; k < N; k++) begin cur_act[k] = 0; cur_prog[k] = k; end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = '0; out_sel = '0; in_sel = '0;
    load = 1'b0; configure = 1'b0; preset = 1'b0;
    model_preset();
    repeat (3) cyc();
    chk(dout, '0, "R11 reset state");
    rst_n = 1'b1;
    repeat (3) cyc();

    // R11/R8: broadcast after reset
    din = 16'h0001; cyc(); chk(dout, 16'hFFFF, "R11 broadcast after reset");
    din = 16'hFFFE; cyc(); chk(dout, 16'h0000, "R11 broadcast input 0 low");

    // R9: commit after reset gives pass-through
    commit();
    check_map("R9 pass-through");

    // Table walk: stage routes, confirm nothing moved, then commit
    for (int v = 0; v < N_LOADS; v++) load_one(int'(LOADS[v][7:4]), int'(LOADS[v][3:0]));
    check_map("R5 staged not active");
    commit();
    for (int k = 0; k < N; k++) cur_act[k] = EXP_MAP[k];
    check_map("R2 R3 R6 table map");

    // R1: output changes only after the next rising edge
    din = 16'h0000; cyc();
    din = 16'hFFFF; #1;
    chk(dout, 16'h0000, "R1 no change before edge");
    cyc();
    chk(dout, 16'hFFFF, "R1 change after one edge");

    // R3: held load follows in_sel, last value kept
    out_sel = 4'd6; load = 1'b1;
    in_sel = 4'd1; cyc();
    in_sel = 4'd2; cyc();
    in_sel = 4'd9; cyc();
    load = 1'b0; cur_prog[6] = 9;
    // R4: address wiggles with load low are ignored
    for (int w = 0; w < 4; w++) begin out_sel = SW'(w * 5); in_sel = SW'(w + 7); cyc(); end
    commit();
    check_map("R3 R4 held load and ignored wiggle");

    // R7: only output 4 changes; other lanes checked every cycle during commit
    load_one(4, 1);
    for (int c = 0; c < 6; c++) begin
      logic [N-1:0] e, m;
      din = N'(16'hA5C3 ^ (c * 16'h3B1D));
      configure = (c == 2);
      cyc();
      configure = 1'b0;
      m = ~(N'(1) << 4);
      for (int k = 0; k < N; k++) e[k] = din[cur_act[k]];
      chk(dout & m, e & m, "R7 unchanged lanes across commit");
    end
    cur_act[4] = 1;

    // R10: preset and load together, preset wins
    out_sel = 4'd2; in_sel = 4'd7; load = 1'b1; preset = 1'b1;
    cyc();
    load = 1'b0; preset = 1'b0;
    model_preset();
    check_map("R8 R10 broadcast after preset");
    commit();
    check_map("R9 R10 pass-through, write dropped");

    // R8: preset with configure high still gives broadcast
    load_one(0, 9);
    preset = 1'b1; configure = 1'b1;
    cyc();
    preset = 1'b0; configure = 1'b0;
    model_preset();
    din = 16'h0001; cyc(); chk(dout, 16'hFFFF, "R8 preset beats commit");

    // R11: asynchronous reset in mid-cycle
    din = 16'hFFFF; cyc();
    #2 rst_n = 1'b0; #1;
    chk(dout, 16'h0000, "R11 async clear");
    cyc(); rst_n = 1'b1;
    repeat (3) cyc();
    din = 16'h0001; cyc(); chk(dout, 16'hFFFF, "R11 broadcast after mid reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule